// File: doc/BRIEF.md
# Debounced Cell-Balance and Overcharge Controller

This block watches a digitised cell-voltage code and drives two protection outputs from it. The first is a balancing sink enable, which turns on the shunt pull-down that bleeds charge from a cell once it has climbed too high. The second is an overcharge flag that tells the charger to stop. Each output follows its own hysteretic channel. The channel enters its active state only after the voltage has met the detect threshold for a whole qualification window. It leaves that state only after the voltage has sat at or below a lower release threshold for a second, shorter window.

The voltage code and all thresholds count in units of 5 mV. The valid threshold range is codes 400 to 920, which is 2.0 V to 4.6 V. Delays are counted on a sample strobe `tick`, one base tick being 0.5 ms / 64. While overcharge is active the balancing sink is held on, whatever state the balancing channel is in. The overcharge flag can be shaped into push-pull or open-drain form, active high or active low.

A test input shortens both detect windows by a factor of 64 and leaves the release windows alone. A power-save input silences everything. A combinational flag reports any configuration that breaks the ordering rules or uses a reserved code.

Top module: `cell_guard`

## Requirements
- R1: Balancing becomes active (state[0]=1, bal_sink=1) on the edge of the Nth consecutive tick with vcode >= bal_det. N is the detect length chosen by bal_dsel.
- R2: A tick on which the qualifying condition fails restarts that channel's count from zero. A full window is needed again after it.
- R3: Balancing ends on the edge of the Mth consecutive tick with vcode <= bal_det minus the hysteresis. M is the release length chosen by bal_rsel. Hysteresis code h gives 0 codes when h=0 and (h+1)*10 codes when h is 1 to 13, so h=1 is 0.1 V.
- R4: The overcharge channel (state[1]) detects and releases the same way, using ovc_det, ovc_hys, ovc_dsel and ovc_rsel.
- R5: Whenever state[1]=1, bal_sink=1.
- R6: co_mode[0]=1 selects active-low and co_mode[1]=1 selects open-drain. Push-pull modes always have co_oe=1 and co_lvl = active XOR co_mode[0]. Open-drain modes have co_lvl=0, and co_oe=1 exactly when the pin is pulled low.
- R7: With tmode=1 the detect lengths are divided by 64. The release lengths do not change.
- R8: A detect select d (0 to 4) gives 8192<<d ticks; values above 4 act as 4. A release select r (0 to 2) gives 64<<r ticks; 3 acts as 2.
- R9: While psave=1, bal_sink=0, state=0 and the overcharge output shows its inactive form in the same cycle. At each clock edge with psave=1, both counts and both channel states are cleared.
- R10: cfg_bad=1 when any of these holds: a detect threshold lies outside 400 to 920; a release threshold lies below 400; a hysteresis code exceeds 13; a delay select is reserved; ovc_det <= bal_det; or ovc_dsel < bal_dsel.
- R11: Channel states change only on edges where tick=1, or where psave=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe, one base tick |
| vcode | input | VW | Cell voltage in 5 mV codes |
| bal_det | input | VW | Balancing detect threshold |
| bal_hys | input | 4 | Balancing hysteresis code |
| bal_dsel | input | 3 | Balancing detect delay select |
| bal_rsel | input | 2 | Balancing release delay select |
| ovc_det | input | VW | Overcharge detect threshold |
| ovc_hys | input | 4 | Overcharge hysteresis code |
| ovc_dsel | input | 3 | Overcharge detect delay select |
| ovc_rsel | input | 2 | Overcharge release delay select |
| co_mode | input | 2 | Overcharge output form and polarity |
| psave | input | 1 | Power-save request |
| tmode | input | 1 | Shortened-detect test mode |
| bal_sink | output | 1 | Balancing pull-down enable |
| co_lvl | output | 1 | Overcharge output level |
| co_oe | output | 1 | Overcharge output drive enable |
| state | output | 2 | {overcharge, balancing} channel states |
| cfg_bad | output | 1 | Configuration rule violation |

## Verification
Two events can land on the same edge: the balancing and overcharge channels can both qualify on one tick, and a power-save request can coincide with the final tick of a window. The random phase sets equal detect selects so that a voltage step above both thresholds makes the two channels flip together. It also raises psave at random moments, some of which fall on the expiring tick. The outputs are compared every cycle with a bench model built from the requirements. That model expects both state bits in the same cycle, and expects psave to win over an expiring count.

// File: rtl/cell_guard.sv
module cell_guard #(
  parameter int VW          = 10,
  parameter int THR_MIN     = 400,
  parameter int THR_MAX     = 920,
  parameter int HYS_UNIT    = 10,
  parameter int HYS_SEL_MAX = 13,
  parameter int DET_TICKS   = 8192,
  parameter int REL_TICKS   = 64,
  parameter int DSEL_MAX    = 4,
  parameter int RSEL_MAX    = 2,
  parameter int TEST_SHIFT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [VW-1:0] vcode,
  input  logic [VW-1:0] bal_det,
  input  logic [3:0]    bal_hys,
  input  logic [2:0]    bal_dsel,
  input  logic [1:0]    bal_rsel,
  input  logic [VW-1:0] ovc_det,
  input  logic [3:0]    ovc_hys,
  input  logic [2:0]    ovc_dsel,
  input  logic [1:0]    ovc_rsel,
  input  logic [1:0]    co_mode,
  input  logic          psave,
  input  logic          tmode,
  output logic          bal_sink,
  output logic          co_lvl,
  output logic          co_oe,
  output logic [1:0]    state,
  output logic          cfg_bad
);
  localparam int CW = $clog2((DET_TICKS << DSEL_MAX) + 1);
  localparam logic [2:0] DMAX = 3'(DSEL_MAX);
  localparam logic [1:0] RMAX = 2'(RSEL_MAX);
  localparam logic [3:0] HMAX = 4'(HYS_SEL_MAX);
  localparam logic [VW-1:0] VMIN = VW'(THR_MIN);
  localparam logic [VW-1:0] VMAX = VW'(THR_MAX);

  function automatic logic [CW-1:0] det_lim(input logic [2:0] s, input logic t);
    int k;
    k = (s > DMAX) ? DSEL_MAX : int'(s);
    return CW'((DET_TICKS << k) >> (t ? TEST_SHIFT : 0));
  endfunction

  function automatic logic [CW-1:0] rel_lim(input logic [1:0] s);
    int k;
    k = (s > RMAX) ? RSEL_MAX : int'(s);
    return CW'(REL_TICKS << k);
  endfunction

  function automatic logic [VW-1:0] rel_thr(input logic [VW-1:0] d, input logic [3:0] h);
    int k;
    logic [VW-1:0] w;
    k = (h > HMAX) ? HYS_SEL_MAX : int'(h);
    w = (h == 4'd0) ? '0 : VW'((k + 1) * HYS_UNIT);
    return (d > w) ? d - w : '0;
  endfunction

  logic [VW-1:0] bal_rel, ovc_rel;
  logic [1:0]    st;

  assign bal_rel = rel_thr(bal_det, bal_hys);
  assign ovc_rel = rel_thr(ovc_det, ovc_hys);

  for (genvar g = 0; g < 2; g++) begin : gch
    logic          on;
    logic [CW-1:0] cnt;
    wire  [VW-1:0] det  = (g == 1) ? ovc_det : bal_det;
    wire  [VW-1:0] rel  = (g == 1) ? ovc_rel : bal_rel;
    wire  [2:0]    dsel = (g == 1) ? ovc_dsel : bal_dsel;
    wire  [1:0]    rsel = (g == 1) ? ovc_rsel : bal_rsel;
    wire           hit  = on ? (vcode <= rel) : (vcode >= det);
    wire  [CW-1:0] lim  = on ? rel_lim(rsel) : det_lim(dsel, tmode);

    always_ff @(posedge clk) begin
      if (!rst_n || psave) begin
        on  <= 1'b0;
        cnt <= '0;
      end else if (tick) begin
        if (!hit) begin
          cnt <= '0;
        end else if (cnt == lim - 1'b1) begin
          on  <= ~on;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign st = {gch[1].on, gch[0].on};

  wire ovc_on = ~psave & st[1];
  assign state    = psave ? 2'b00 : st;
  assign bal_sink = ~psave & (st[0] | st[1]);
  assign co_lvl   = co_mode[1] ? 1'b0 : (ovc_on ^ co_mode[0]);
  assign co_oe    = co_mode[1] ? (ovc_on ^ ~co_mode[0]) : 1'b1;

  assign cfg_bad = (bal_det < VMIN) || (bal_det > VMAX) ||
                   (ovc_det < VMIN) || (ovc_det > VMAX) ||
                   (bal_rel < VMIN) || (ovc_rel < VMIN) ||
                   (bal_hys > HMAX) || (ovc_hys > HMAX) ||
                   (bal_dsel > DMAX) || (ovc_dsel > DMAX) ||
                   (bal_rsel > RMAX) || (ovc_rsel > RMAX) ||
                   (ovc_det <= bal_det) || (ovc_dsel < bal_dsel);
endmodule

// File: rtl/cell_guard_chk.sv
module cell_guard_chk #(
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          psave,
  input logic [VW-1:0] vcode,
  input logic [VW-1:0] bal_det,
  input logic [VW-1:0] ovc_det,
  input logic [1:0]    co_mode,
  input logic          bal_sink,
  input logic          co_lvl,
  input logic          co_oe,
  input logic [1:0]    state
);
  AST_BAL_DET_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state[0]) |-> $past(tick && vcode >= bal_det)); // R1
  AST_BAL_REL_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state[0]) && !psave |-> $past(tick && vcode <= bal_det)); // R3
  AST_OVC_DET_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state[1]) |-> $past(tick && vcode >= ovc_det)); // R4
  AST_OVC_FORCES_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    state[1] |-> bal_sink); // R5
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    co_mode[1] && co_oe |-> !co_lvl); // R6
  AST_PUSHPULL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !co_mode[1] |-> co_oe); // R6
  AST_PSAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    psave |-> !bal_sink && state == 2'b00); // R9
  AST_TICK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) && !$past(psave) && !psave |-> $stable(state)); // R11
endmodule

bind cell_guard cell_guard_chk #(.VW(VW)) u_chk (.*);

// File: tb/tb_cell_guard.sv
`timescale 1ns/1ps
module tb_cell_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b1, psave = 1'b0, tmode = 1'b1;
  logic [9:0] vcode = 10'd500, bal_det = 10'd600, ovc_det = 10'd640;
  logic [3:0] bal_hys = 4'd1, ovc_hys = 4'd0;
  logic [2:0] bal_dsel = 3'd0, ovc_dsel = 3'd1;
  logic [1:0] bal_rsel = 2'd0, ovc_rsel = 2'd0, co_mode = 2'd0;
  logic bal_sink, co_lvl, co_oe, cfg_bad;
  logic [1:0] state;
  int total = 0, bad = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  cell_guard dut (.clk(clk), .rst_n(rst_n), .tick(tick), .vcode(vcode),
    .bal_det(bal_det), .bal_hys(bal_hys), .bal_dsel(bal_dsel), .bal_rsel(bal_rsel),
    .ovc_det(ovc_det), .ovc_hys(ovc_hys), .ovc_dsel(ovc_dsel), .ovc_rsel(ovc_rsel),
    .co_mode(co_mode), .psave(psave), .tmode(tmode), .bal_sink(bal_sink),
    .co_lvl(co_lvl), .co_oe(co_oe), .state(state), .cfg_bad(cfg_bad));

  function automatic int det_len(int s, bit t);
    int k = (s > 4) ? 4 : s;
    return (8192 << k) >> (t ? 6 : 0);
  endfunction
  function automatic int rel_len(int s);
    return 64 << ((s > 2) ? 2 : s);
  endfunction
  function automatic int rel_of(int d, int h);
    int w = (h == 0) ? 0 : (((h > 13) ? 13 : h) + 1) * 10;
    return (d > w) ? d - w : 0;
  endfunction
  function automatic logic [1:0] co_exp(bit act, logic [1:0] m);
    if (m[1]) return {1'b0, act ? m[0] : ~m[0]};
    return {act ^ m[0], 1'b1};
  endfunction

  int m_st[2], m_cnt[2];
  always @(posedge clk) begin
    if (!rst_n || psave) begin
      for (int c = 0; c < 2; c++) begin m_st[c] = 0; m_cnt[c] = 0; end
    end else if (tick) begin
      for (int c = 0; c < 2; c++) begin
        int det, rel, lim; bit ok;
        det = c ? int'(ovc_det) : int'(bal_det);
        rel = c ? rel_of(ovc_det, ovc_hys) : rel_of(bal_det, bal_hys);
        lim = m_st[c] ? rel_len(c ? ovc_rsel : bal_rsel) : det_len(c ? ovc_dsel : bal_dsel, tmode);
        ok  = m_st[c] ? (int'(vcode) <= rel) : (int'(vcode) >= det);
        if (!ok) m_cnt[c] = 0;
        else if (m_cnt[c] == lim - 1) begin m_st[c] = 1 - m_st[c]; m_cnt[c] = 0; end
        else m_cnt[c]++;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask
  task automatic adv(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask
  task automatic chk_st(logic [1:0] e, string tag);
    chk(state == e && bal_sink == (e != 0), tag, {bal_sink, state}, {e != 0, e});
  endtask

  always @(negedge clk) if (cmp_on) begin
    logic [1:0] es, co;
    es = psave ? 2'b00 : 2'(m_st[1] * 2 + m_st[0]);
    co = co_exp(es[1], co_mode);
    chk(state == es && bal_sink == (es != 0) && {co_lvl, co_oe} == co, "R1 R4 R5 R9 random",
        {state, bal_sink, co_lvl, co_oe}, {es, es != 0, co});
  end

  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    adv(3); rst_n = 1'b1; adv(2);
    chk_st(2'b00, "R1 reset");
    chk({co_lvl, co_oe} == 2'b01, "R6 reset", {co_lvl, co_oe}, 1);
    chk(cfg_bad == 0, "R10 good cfg", cfg_bad, 0);
    // R1
    vcode = 600; adv(127); chk_st(2'b00, "R1 early");
    adv(1); chk_st(2'b01, "R1 detect");
    // R3 hysteresis 0.1 V: release at 580
    vcode = 581; adv(200); chk_st(2'b01, "R3 above rel");
    vcode = 580; adv(63); chk_st(2'b01, "R3 early");
    adv(1); chk_st(2'b00, "R3 R7 release");
    // R2 restart
    vcode = 600; adv(100); vcode = 599; adv(1); vcode = 600;
    adv(127); chk_st(2'b00, "R2 restart");
    adv(1); chk_st(2'b01, "R2 full window");
    // R4 overcharge, detect sel 1 -> 256 in test mode
    vcode = 640; adv(255); chk_st(2'b01, "R4 early");
    adv(1); chk_st(2'b11, "R4 detect");
    chk(co_lvl == 1, "R4 R6 flag", co_lvl, 1);
    vcode = 620; adv(63); chk_st(2'b11, "R4 rel early");
    adv(1); chk_st(2'b01, "R4 release");
    // R8 release select 2
    bal_rsel = 2; vcode = 500; adv(255); chk_st(2'b01, "R8 rel early");
    adv(1); chk_st(2'b00, "R8 rel 256"); bal_rsel = 0;
    // R7 normal detect length
    tmode = 0; vcode = 600; adv(8191); chk_st(2'b00, "R7 normal early");
    adv(1); chk_st(2'b01, "R7 normal detect");
    vcode = 500; adv(63); chk_st(2'b01, "R7 rel early");
    adv(1); chk_st(2'b00, "R7 release unchanged"); tmode = 1;
    // R5 and R10: overcharge alone
    bal_det = 700; #1; chk(cfg_bad == 1, "R10 order", cfg_bad, 1);
    vcode = 650; adv(200); psave = 1; adv(1); psave = 0;
    adv(255); chk_st(2'b00, "R9 counts cleared");
    adv(1); chk(state == 2'b10 && bal_sink, "R5 forced sink", {bal_sink, state}, 6);
    for (int m = 0; m < 4; m++) begin
      co_mode = 2'(m); #1;
      chk({co_lvl, co_oe} == co_exp(1, co_mode), "R6 active", {co_lvl, co_oe}, co_exp(1, co_mode));
    end
    psave = 1; #1;
    chk(state == 0 && !bal_sink && {co_lvl, co_oe} == co_exp(0, co_mode), "R9 quiet",
        {state, bal_sink, co_lvl, co_oe}, co_exp(0, co_mode));
    adv(2); psave = 0; adv(1); chk_st(2'b00, "R9 cleared");
    vcode = 500; bal_det = 600;
    for (int m = 0; m < 4; m++) begin
      co_mode = 2'(m); #1;
      chk({co_lvl, co_oe} == co_exp(0, co_mode), "R6 idle", {co_lvl, co_oe}, co_exp(0, co_mode));
    end
    co_mode = 0;
    // R10 rules
    bal_dsel = 1; ovc_dsel = 0; #1; chk(cfg_bad == 1, "R10 delay order", cfg_bad, 1);
    ovc_dsel = 1; bal_hys = 14; #1; chk(cfg_bad == 1, "R10 hys reserved", cfg_bad, 1);
    bal_hys = 1; bal_det = 399; #1; chk(cfg_bad == 1, "R10 low thr", cfg_bad, 1);
    bal_det = 600; ovc_rsel = 3; #1; chk(cfg_bad == 1, "R10 rsel reserved", cfg_bad, 1);
    ovc_rsel = 0; bal_dsel = 0; #1; chk(cfg_bad == 0, "R10 clean", cfg_bad, 0);
    // R11 no ticks
    adv(1); tick = 0; vcode = 600; adv(500); chk_st(2'b00, "R11 no tick");
    tick = 1; adv(127); chk_st(2'b00, "R11 early");
    adv(1); chk_st(2'b01, "R11 detect");
    // random phase, equal detect selects
    ovc_dsel = 0; ovc_det = 620; vcode = 500; adv(70);
    cmp_on = 1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 150 == 0) vcode = 10'(570 + $urandom % 80);
      tick  = ($urandom % 4) != 0;
      psave = ($urandom % 400) == 0;
      if ($urandom % 300 == 0) co_mode = 2'($urandom);
      adv(1);
    end
    vcode = 500; tick = 1; psave = 0; adv(1);
    vcode = 650; adv(127);
    chk_st(2'b00, "R1 R4 tie early");
    adv(1); chk_st(2'b11, "R1 R4 same tick");
    cmp_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule